// File: doc/BRIEF.md
# Delay-Line Initialization Sequencer

This block brings a programmable sampling delay line out of reset before a tuning sweep runs. After a start strobe it drives a fixed series of register updates over a single-master register port. It first stops the clock power-saver in the vendor control word, so the clock cannot stop during calibration. It then takes the line through reset and power-down, writes a clock-band code chosen from the configured bus clock rate, releases reset and power-down, and turns on the line and its output clock. It ends by polling a lock flag at one-microsecond spacing.

Each bit change is a separate read-modify-write: the word is read, the one field is changed, and the word is written back. At most one access is outstanding at any time. The block reports the result with a one-cycle `done` pulse when lock is seen, or a one-cycle `timeout` pulse when the poll budget runs out without lock.

Top module: `dis_init_seq`

## Requirements
- R1: The first access after an accepted start is a read of offset 0x10C. It is followed by a write to 0x10C of the value read with bit 1 cleared and every other bit unchanged.
- R2: The seven following changes all target offset 0x100, in this order: set bit 30, set bit 29, write the band code, clear bit 30, clear bit 29, set bit 16, set bit 18.
- R3: The band code sits in bits 26:24 and uses inclusive upper bounds on the rate sampled at start: ≤112 MHz gives 0, ≤125 gives 1, ≤137 gives 2, ≤150 gives 3, ≤162 gives 4, ≤175 gives 5, ≤187 gives 6, ≤200 gives 7. Any rate above 200 MHz gives 0.
- R4: Each change is a read of the target word followed by a write of that word to the same offset. The write carries all bits other than the changed field as they were read.
- R5: Only one bus access is outstanding. Request, direction, offset and write data stay stable from request until acknowledge.
- R6: After the last configuration write the block reads offset 0x108. When bit 7 of a read is 1, `done` pulses in the cycle that follows that read's acknowledge.
- R7: At most MAX_POLLS status reads are made. Successive reads are at least TICKS_PER_US cycles apart. If none of them shows lock, `timeout` pulses and no further access is made.
- R8: A start is ignored while a sequence is running, and the clock rate input is sampled only when a start is accepted. A start in the cycle where `done` or `timeout` is high is accepted.
- R9: After reset `done`, `timeout` and the bus request are low. `done` and `timeout` are never high together, and each is high for exactly one cycle per sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, accepted only when idle |
| bus_clk_hz | input | 32 | Configured bus clock rate in Hz |
| bus_req | output | 1 | Register access request, held until acknowledge |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 12 | Register byte offset |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access acknowledge, one cycle |
| bus_rdata | input | 32 | Read data, valid with acknowledge |
| done | output | 1 | One-cycle pulse: lock seen |
| timeout | output | 1 | One-cycle pulse: lock not seen within the poll budget |

## Verification
Two pairs of events can land in one cycle. The first pair is the lock flag arriving on the very last permitted status read, which races the timeout decision. The bench makes lock appear exactly on read number MAX_POLLS and expects `done` with no `timeout` after exactly MAX_POLLS status reads. The second pair is a new start arriving in the same cycle as the completion pulse. The bench raises start while `done` is high and expects a second, complete and correctly ordered access sequence that uses the newly presented clock rate. For contrast, a start raised mid-run must leave the access count and the band code unchanged.

// File: rtl/dis_pkg.sv
package dis_pkg;

  localparam int unsigned DW        = 32;
  localparam int unsigned AW        = 12;
  localparam int unsigned NUM_STEPS = 8;
  localparam int unsigned STEP_W    = $clog2(NUM_STEPS);
  localparam int unsigned BAND_W    = 3;

  // Register offsets
  localparam logic [AW-1:0] VEND_OFS = 12'h10C;
  localparam logic [AW-1:0] CFG_OFS  = 12'h100;
  localparam logic [AW-1:0] STAT_OFS = 12'h108;

  // Bit positions the delay line decodes
  localparam int unsigned PWRSAVE_BIT = 1;
  localparam int unsigned RST_BIT     = 30;
  localparam int unsigned PDN_BIT     = 29;
  localparam int unsigned EN_BIT      = 16;
  localparam int unsigned CKOUT_BIT   = 18;
  localparam int unsigned LOCK_BIT    = 7;
  localparam int unsigned BAND_LSB    = 24;

  typedef logic [BAND_W-1:0] band_t;
  typedef logic [STEP_W-1:0] step_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_ISSUE, ST_RD_WAIT, ST_WR_ISSUE,
    ST_WR_WAIT, ST_PL_ISSUE, ST_PL_WAIT, ST_PL_GAP
  } seq_state_e;

  // Clock-rate band: inclusive upper bounds, fall-through above the top band is 0
  function automatic band_t hz_to_band(input logic [31:0] hz);
    band_t b;
    if      (hz <= 32'd112_000_000) b = 3'd0;
    else if (hz <= 32'd125_000_000) b = 3'd1;
    else if (hz <= 32'd137_000_000) b = 3'd2;
    else if (hz <= 32'd150_000_000) b = 3'd3;
    else if (hz <= 32'd162_000_000) b = 3'd4;
    else if (hz <= 32'd175_000_000) b = 3'd5;
    else if (hz <= 32'd187_000_000) b = 3'd6;
    else if (hz <= 32'd200_000_000) b = 3'd7;
    else                            b = 3'd0;
    return b;
  endfunction

  // Offset touched by each step of the bring-up
  function automatic logic [AW-1:0] step_offset(input step_t s);
    return (s == '0) ? VEND_OFS : CFG_OFS;
  endfunction

  // Field change applied by each step to the word just read
  function automatic logic [DW-1:0] step_modify(input step_t s,
                                                input logic [DW-1:0] cur,
                                                input band_t band);
    logic [DW-1:0] r;
    r = cur;
    case (s)
      3'd0: r[PWRSAVE_BIT] = 1'b0;
      3'd1: r[RST_BIT]     = 1'b1;
      3'd2: r[PDN_BIT]     = 1'b1;
      3'd3: r[BAND_LSB +: BAND_W] = band;
      3'd4: r[RST_BIT]     = 1'b0;
      3'd5: r[PDN_BIT]     = 1'b0;
      3'd6: r[EN_BIT]      = 1'b1;
      default: r[CKOUT_BIT] = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dis_freq_band.sv
module dis_freq_band
  import dis_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        capture,
  input  logic [31:0] hz,
  output band_t       band_q
);

  band_t band_d;
  assign band_d = hz_to_band(hz);

  always_ff @(posedge clk) begin
    if (!rst_n)       band_q <= '0;
    else if (capture) band_q <= band_d;
  end

endmodule

// File: rtl/dis_bus_port.sv
module dis_bus_port
  import dis_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic          issue_wr,
  input  logic [AW-1:0] issue_addr,
  input  logic [DW-1:0] issue_data,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);

  assign rsp_valid = bus_req & bus_ack;
  assign rsp_data  = bus_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else if (rsp_valid) begin
      bus_req <= 1'b0;
    end else if (issue) begin
      bus_req   <= 1'b1;
      bus_we    <= issue_wr;
      bus_addr  <= issue_addr;
      bus_wdata <= issue_data;
    end
  end

  // R5: a new access is only launched when nothing is outstanding
  assert_single_flight_R5: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !bus_req);

  // R5: an outstanding access holds its attributes until acknowledged
  assert_hold_until_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));

endmodule

// File: rtl/dis_poll_pacer.sv
module dis_poll_pacer #(
  parameter int unsigned TICKS_PER_US = 100,
  parameter int unsigned MAX_POLLS    = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic miss,
  input  logic gap_run,
  output logic gap_done,
  output logic last_poll
);

  localparam int unsigned PW = $clog2(MAX_POLLS) + 1;
  localparam int unsigned TW = $clog2(TICKS_PER_US) + 1;

  logic [PW-1:0] poll_idx;
  logic [TW-1:0] tick;

  always_ff @(posedge clk) begin
    if (!rst_n)     poll_idx <= '0;
    else if (clear) poll_idx <= '0;
    else if (miss)  poll_idx <= poll_idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !gap_run) tick <= '0;
    else                    tick <= tick + 1'b1;
  end

  assign gap_done  = gap_run && (tick == TW'(TICKS_PER_US - 1));
  assign last_poll = (poll_idx == PW'(MAX_POLLS - 1));

  // R7: the poll index never passes the budget
  assert_poll_budget_R7: assert property (@(posedge clk) disable iff (!rst_n)
    poll_idx <= PW'(MAX_POLLS - 1));

  // R7: a miss is never recorded on the final allowed poll
  assert_no_miss_past_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> !last_poll);

endmodule

// File: rtl/dis_init_seq.sv
module dis_init_seq
  import dis_pkg::*;
#(
  parameter int unsigned TICKS_PER_US = 100,
  parameter int unsigned MAX_POLLS    = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] bus_clk_hz,
  output logic        bus_req,
  output logic        bus_we,
  output logic [11:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic        bus_ack,
  input  logic [31:0] bus_rdata,
  output logic        done,
  output logic        timeout
);

  seq_state_e    state_q, state_d;
  step_t         step_q;
  logic [DW-1:0] rmw_q;
  band_t         band_q;
  logic          done_q, timeout_q;

  logic          issue, issue_wr;
  logic [AW-1:0] issue_addr;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          gap_done, last_poll;

  // Named internal events
  logic accept, last_step, lock_hit, poll_miss, cfg_finished;
  assign accept       = start && (state_q == ST_IDLE);
  assign last_step    = (step_q == STEP_W'(NUM_STEPS - 1));
  assign lock_hit     = (state_q == ST_PL_WAIT) && rsp_valid &&  rsp_data[LOCK_BIT];
  assign poll_miss    = (state_q == ST_PL_WAIT) && rsp_valid && !rsp_data[LOCK_BIT];
  assign cfg_finished = (state_q == ST_WR_WAIT) && rsp_valid && last_step;

  assign issue      = (state_q == ST_RD_ISSUE) || (state_q == ST_WR_ISSUE) || (state_q == ST_PL_ISSUE);
  assign issue_wr   = (state_q == ST_WR_ISSUE);
  assign issue_addr = (state_q == ST_PL_ISSUE) ? STAT_OFS : step_offset(step_q);

  dis_freq_band u_band (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (accept),
    .hz      (bus_clk_hz),
    .band_q  (band_q)
  );

  dis_bus_port u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (issue),
    .issue_wr   (issue_wr),
    .issue_addr (issue_addr),
    .issue_data (rmw_q),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_ack    (bus_ack),
    .bus_rdata  (bus_rdata),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data)
  );

  dis_poll_pacer #(
    .TICKS_PER_US (TICKS_PER_US),
    .MAX_POLLS    (MAX_POLLS)
  ) u_pacer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (cfg_finished),
    .miss      (poll_miss && !last_poll),
    .gap_run   (state_q == ST_PL_GAP),
    .gap_done  (gap_done),
    .last_poll (last_poll)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (start)     state_d = ST_RD_ISSUE;
      ST_RD_ISSUE:                state_d = ST_RD_WAIT;
      ST_RD_WAIT:  if (rsp_valid) state_d = ST_WR_ISSUE;
      ST_WR_ISSUE:                state_d = ST_WR_WAIT;
      ST_WR_WAIT:  if (rsp_valid) state_d = last_step ? ST_PL_ISSUE : ST_RD_ISSUE;
      ST_PL_ISSUE:                state_d = ST_PL_WAIT;
      ST_PL_WAIT:  if (rsp_valid) state_d = (lock_hit || last_poll) ? ST_IDLE : ST_PL_GAP;
      ST_PL_GAP:   if (gap_done)  state_d = ST_PL_ISSUE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      step_q    <= '0;
      rmw_q     <= '0;
      done_q    <= 1'b0;
      timeout_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      done_q    <= lock_hit;
      timeout_q <= poll_miss && last_poll;
      if (accept)
        step_q <= '0;
      else if ((state_q == ST_WR_WAIT) && rsp_valid && !last_step)
        step_q <= step_q + 1'b1;
      if ((state_q == ST_RD_WAIT) && rsp_valid)
        rmw_q <= step_modify(step_q, rsp_data, band_q);
    end
  end

  assign done    = done_q;
  assign timeout = timeout_q;

  // Offset of the most recent completed read, for the RMW pairing check
  logic [AW-1:0] last_rd_addr_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                    last_rd_addr_q <= '0;
    else if (rsp_valid && !bus_we) last_rd_addr_q <= bus_addr;
  end

  // R4: every write lands on the offset that was just read
  assert_rmw_same_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |-> (bus_addr == last_rd_addr_q));

  // R6: a status read showing lock is followed by done
  assert_lock_gives_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_hit |=> done);

  // R8: the sampled band holds for the whole run
  assert_band_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(band_q));

  // R9: completion flags are single-cycle and exclusive
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_timeout_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);
  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));

endmodule

// File: tb/dis_init_seq_tb.sv
module dis_init_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TICKS      = 8;
  localparam int MAXP       = 50;
  localparam int WATCHDOG   = 150000;
  localparam logic [11:0] A_VEND = 12'h10C;
  localparam logic [11:0] A_CFG  = 12'h100;
  localparam logic [11:0] A_STAT = 12'h108;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] bus_clk_hz = 32'd100_000_000;
  logic        bus_req, bus_we;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic        done, timeout;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dis_init_seq #(.TICKS_PER_US(TICKS), .MAX_POLLS(MAXP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .bus_clk_hz(bus_clk_hz),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .done(done), .timeout(timeout)
  );

  // ---------------- register-file model ----------------
  logic        load = 1'b0;
  logic [31:0] preset_v = '0, preset_c = '0;
  int          lock_after = 0;
  logic [31:0] vend_r = '0, cfg_r = '0;
  int          stat_reads = 0;
  int          n_acc = 0;
  logic [11:0] acc_addr [0:127];
  logic        acc_we   [0:127];
  logic [31:0] acc_data [0:127];
  int          cyc = 0;
  int          prev_stat = 0;
  int          min_gap = 1000000;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (load) begin
      vend_r <= preset_v; cfg_r <= preset_c;
      stat_reads <= 0; n_acc <= 0; min_gap <= 1000000;
      bus_ack <= 1'b0;
    end else if (!rst_n) begin
      bus_ack <= 1'b0;
    end else if (bus_req && !bus_ack) begin
      bus_ack <= 1'b1;
      if (n_acc < 128) begin
        acc_addr[n_acc] <= bus_addr;
        acc_we[n_acc]   <= bus_we;
        acc_data[n_acc] <= bus_wdata;
      end
      n_acc <= n_acc + 1;
      if (bus_we) begin
        if (bus_addr == A_VEND) vend_r <= bus_wdata;
        else if (bus_addr == A_CFG) cfg_r <= bus_wdata;
      end else begin
        if (bus_addr == A_VEND)      bus_rdata <= vend_r;
        else if (bus_addr == A_CFG)  bus_rdata <= cfg_r;
        else if (bus_addr == A_STAT) begin
          bus_rdata <= (stat_reads >= lock_after) ? 32'h0000_0381 : 32'h0000_0301;
          if (stat_reads > 0 && (cyc - prev_stat) < min_gap) min_gap <= cyc - prev_stat;
          prev_stat  <= cyc;
          stat_reads <= stat_reads + 1;
        end else bus_rdata <= 32'hDEAD_BEEF;
        if (n_acc < 128) acc_data[n_acc] <= 32'h0;
      end
    end else begin
      bus_ack <= 1'b0;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] ref_band(input logic [31:0] hz);
    int bounds [8] = '{112, 125, 137, 150, 162, 175, 187, 200};
    for (int i = 0; i < 8; i++)
      if (64'(hz) <= 64'(bounds[i]) * 64'd1_000_000) return 3'(i);
    return 3'd0;
  endfunction

  task automatic preload(input logic [31:0] v, input logic [31:0] c, input int lk);
    @(negedge clk);
    preset_v = v; preset_c = c; lock_after = lk; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic wait_end(output bit sd, output bit st);
    for (int i = 0; i < 20000 && !done && !timeout; i++) @(negedge clk);
    sd = done; st = timeout;
  endtask

  // Compare the access log from base against the expected bring-up
  task automatic verify_log(input int base, input logic [31:0] v0, input logic [31:0] c0,
                            input logic [2:0] code, input string req);
    logic [31:0] c;
    logic [31:0] nx;
    check(acc_addr[base] == A_VEND && !acc_we[base], "R1", "first access read of vendor word",
          {19'd0, acc_we[base], acc_addr[base]}, {20'd0, A_VEND});
    check(acc_addr[base+1] == A_VEND && acc_we[base+1] && acc_data[base+1] == (v0 & 32'hFFFF_FFFD),
          "R1", "power-save clear write", acc_data[base+1], v0 & 32'hFFFF_FFFD);
    c = c0;
    for (int j = 0; j < 7; j++) begin
      case (j)
        0: nx = c | 32'h4000_0000;
        1: nx = c | 32'h2000_0000;
        2: nx = (c & 32'hF8FF_FFFF) | ({29'd0, code} << 24);
        3: nx = c & 32'hBFFF_FFFF;
        4: nx = c & 32'hDFFF_FFFF;
        5: nx = c | 32'h0001_0000;
        default: nx = c | 32'h0004_0000;
      endcase
      check(acc_addr[base+2+2*j] == A_CFG && !acc_we[base+2+2*j], req, "config read before change",
            {19'd0, acc_we[base+2+2*j], acc_addr[base+2+2*j]}, {20'd0, A_CFG});
      check(acc_addr[base+3+2*j] == A_CFG && acc_we[base+3+2*j] && acc_data[base+3+2*j] == nx,
            req, "config write value", acc_data[base+3+2*j], nx);
      c = nx;
    end
    check(acc_addr[base+16] == A_STAT && !acc_we[base+16], "R6", "status read after config",
          {20'd0, acc_addr[base+16]}, {20'd0, A_STAT});
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(done == 1'b0 && timeout == 1'b0, "R9", "flags low in reset", {30'd0, done, timeout}, 0);
    check(bus_req == 1'b0, "R9", "no request in reset", {31'd0, bus_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_basic();
    bit sd, st, pulse_ok;
    preload(32'hFFFF_FFFF, 32'h0000_0000, 0);
    bus_clk_hz = 32'd100_000_000; start = 1'b1; @(negedge clk); start = 1'b0;
    wait_end(sd, st);
    @(negedge clk); pulse_ok = !done && !timeout;
    check(sd && !st, "R6", "immediate lock gives done", {30'd0, sd, st}, 32'h2);
    check(pulse_ok, "R9", "done lasts one cycle", {31'd0, pulse_ok}, 1);
    check(stat_reads == 1, "R6", "single status read", stat_reads, 1);
    check(n_acc == 17, "R4", "access count", n_acc, 17);
    verify_log(0, 32'hFFFF_FFFF, 32'h0, 3'd0, "R2");
  endtask

  task automatic t_band(input logic [31:0] hz);
    bit sd, st;
    logic [2:0] exp;
    exp = ref_band(hz);
    preload(32'h1234_5672, 32'h5A5A_A5A5, 0);
    bus_clk_hz = hz; start = 1'b1; @(negedge clk); start = 1'b0;
    wait_end(sd, st);
    @(negedge clk);
    check(cfg_r[26:24] == exp, "R3", $sformatf("band code for %0d Hz", hz), {29'd0, cfg_r[26:24]}, {29'd0, exp});
    verify_log(0, 32'h1234_5672, 32'h5A5A_A5A5, exp, "R4");
  endtask

  task automatic t_late_lock();
    bit sd, st;
    preload(32'h0, 32'h0, MAXP - 1);
    bus_clk_hz = 32'd150_000_000; start = 1'b1; @(negedge clk); start = 1'b0;
    wait_end(sd, st);
    check(sd && !st, "R6", "lock on last allowed poll gives done", {30'd0, sd, st}, 32'h2);
    check(stat_reads == MAXP, "R7", "poll count with late lock", stat_reads, MAXP);
    check(min_gap >= TICKS, "R7", "spacing between polls", min_gap, TICKS);
    @(negedge clk);
  endtask

  task automatic t_timeout();
    bit sd, st, pulse_ok;
    int n_end;
    preload(32'h0, 32'h0, 100000);
    bus_clk_hz = 32'd200_000_000; start = 1'b1; @(negedge clk); start = 1'b0;
    wait_end(sd, st);
    @(negedge clk); pulse_ok = !done && !timeout;
    check(st && !sd, "R7", "no lock gives timeout", {30'd0, sd, st}, 32'h1);
    check(pulse_ok, "R9", "timeout lasts one cycle", {31'd0, pulse_ok}, 1);
    check(stat_reads == MAXP, "R7", "poll budget", stat_reads, MAXP);
    n_end = n_acc;
    repeat (40) @(negedge clk);
    check(n_acc == n_end && !bus_req, "R7", "no access after timeout", n_acc, n_end);
  endtask

  task automatic t_busy_start();
    bit sd, st;
    int n_end;
    preload(32'h0, 32'h0, 2);
    bus_clk_hz = 32'd130_000_000; start = 1'b1; @(negedge clk); start = 1'b0;
    bus_clk_hz = 32'd250_000_000;
    repeat (9) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_end(sd, st);
    check(sd, "R8", "run completes despite mid-run start", {31'd0, sd}, 1);
    check(cfg_r[26:24] == 3'd2, "R8", "band from rate at accepted start", {29'd0, cfg_r[26:24]}, 2);
    n_end = n_acc;
    repeat (40) @(negedge clk);
    check(n_acc == 19 && n_acc == n_end, "R8", "mid-run start ignored", n_acc, 19);
  endtask

  task automatic t_back_to_back();
    bit sd, st;
    preload(32'hAAAA_AAAA, 32'h0000_0000, 0);
    bus_clk_hz = 32'd170_000_000; start = 1'b1; @(negedge clk); start = 1'b0;
    wait_end(sd, st);
    check(sd, "R6", "first run done", {31'd0, sd}, 1);
    bus_clk_hz = 32'd118_000_000; start = 1'b1; @(negedge clk); start = 1'b0;
    wait_end(sd, st);
    check(sd && !st, "R8", "start in done cycle accepted", {30'd0, sd, st}, 32'h2);
    check(n_acc == 34, "R8", "two full sequences", n_acc, 34);
    verify_log(17, 32'hAAAA_AAA8, 32'h0004_0000 | 32'h0001_0000 | 32'h0500_0000, 3'd1, "R2");
    @(negedge clk);
  endtask

  // ---------------- main ----------------
  bit finished = 1'b0;

  initial begin
    t_reset();
    t_basic();
    t_band(32'd112_000_000);
    t_band(32'd112_000_001);
    t_band(32'd137_000_000);
    t_band(32'd162_000_000);
    t_band(32'd187_000_001);
    t_band(32'd200_000_000);
    t_band(32'd200_000_001);
    t_late_lock();
    t_timeout();
    t_busy_start();
    t_back_to_back();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(negedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=expired expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule